// File: doc/BRIEF.md
# Programmable Tap-Select Binary Timer

This block is a 24-stage binary divider that runs on the system clock. A single-cycle count strobe stands in for the slow timer clock. One output, `tap_out`, follows one stage of the upper sixteen stages. A 4-bit code picks that stage. The usual use is to derive long timing intervals from a steady event stream. The code sets the interval, and a skip control shortens the chain by one byte. That control feeds the strobe straight into stage 9, so the upper sixteen stages count as a 16-bit divider of their own.

There are a few more controls. A hold input blocks counting. Two synchronous controls load every stage with all zeros or all ones. A production test mode starts when the skip, preset and clear controls are all high at the same time. In that mode the chain breaks into three independent byte sections, and each one counts every strobe. A full-length chain can then be exercised in a few hundred strobes.

Top module: `tap_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, all 24 stages clear to 0 at that edge, so `tap_out` reads 0 for every select code.
- R2: Select code k (0 to 15 on `tap_sel`) routes stage k+9 to `tap_out`, with no register in between. Stage 1 is the least significant bit of the count, so code k shows count bit k+8.
- R3: With `skip_low`, `preset` and `clear` low, each edge with `cnt_en`=1 and `hold`=0 adds one to the 24-bit count. The count wraps from all ones to zero.
- R4: With `skip_low`=1 and not in test mode, each step adds one to stages 9 to 24 as a 16-bit count, which wraps after 65536 steps. Stages 1 to 8 keep their value.
- R5: While `hold`=1, a strobe changes no stage. This applies in normal, skip and test mode.
- R6: Outside test mode, `clear`=1 zeroes all stages at the next edge. It takes priority over `preset` and over counting.
- R7: Outside test mode, `preset`=1 with `clear`=0 sets all 24 stages to 1 at the next edge, overriding counting.
- R8: While `skip_low`, `preset` and `clear` are all 1, each step adds one to each of the three 8-stage sections independently. No carry passes between sections, and the preset and clear controls have no effect.
- R9: An edge with `cnt_en`=0 and with `preset` and `clear` low changes no stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Count strobe, one step per high cycle |
| hold | input | 1 | Blocks counting while high |
| skip_low | input | 1 | Bypasses stages 1 to 8 |
| preset | input | 1 | Loads all ones |
| clear | input | 1 | Loads all zeros, priority over preset |
| tap_sel | input | 4 | Selects stage 9 + code for the output |
| tap_out | output | 1 | Value of the selected stage |

## Verification
Stages 1 to 8 never reach a port, so their behaviour can only be seen through carries into stage 9. The bench first loads all ones. It then steps once with the skip on, which should leave the low byte full. It then steps once with the skip off and expects a carry into stage 9. Test mode follows the same idea: the sections step past 256 without carrying, then normal counting resumes. How far the hidden low byte has to go before it carries shows that it counted. Each observation sweeps all sixteen select codes to rebuild the upper 16 bits, and compares them with an arithmetic model.

// File: rtl/tap_timer_pkg.sv
// Package: shared control record for the tap-select timer.
// Assumes one decoded control set is valid per system clock cycle.
package tap_timer_pkg;

    // Decoded per-cycle action for the stage sections
    typedef struct packed {
        logic test;   // sections count in parallel
        logic zero;   // load all zeros
        logic ones;   // load all ones
        logic step;   // a counting step is due this cycle
        logic skip;   // lowest section is bypassed
    } tt_ctl_t;

endpackage

// File: rtl/tap_timer_ctrl.sv
// Control decoder: turns the raw control pins into one action per cycle.
// Priority: test mode > clear > preset > counting. The hold input blocks steps only.
module tap_timer_ctrl
    import tap_timer_pkg::*;
(
    input  logic    cnt_en,
    input  logic    hold,
    input  logic    skip_low,
    input  logic    preset,
    input  logic    clear,
    output tt_ctl_t ctl
);

    logic test_w;

    // Test mode exists only while all three mode controls are high together
    always_comb begin
        test_w = skip_low & preset & clear;
    end

    // Build the action record with the stated priorities
    always_comb begin
        ctl.test = test_w;
        ctl.zero = clear & ~test_w;
        ctl.ones = preset & ~clear & ~test_w;
        ctl.step = cnt_en & ~hold & ~(clear & ~test_w) & ~(preset & ~test_w);
        ctl.skip = skip_low;
    end

endmodule

// File: rtl/tap_timer_section.sv
// One byte-wide (parameterised) counting section of the divider chain.
// Assumes the loads and the increment are already prioritised by the caller.
module tap_timer_section #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         ld_zero,
    input  logic         ld_ones,
    output logic [W-1:0] q,
    output logic         wrap
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // Section register: reset, load or count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (ld_zero) begin
            q <= '0;
        end else if (ld_ones) begin
            q <= '1;
        end else if (inc) begin
            q <= q + ONE;
        end
    end

    // Carry to the next section when this one rolls over
    always_comb begin
        wrap = inc & (&q);
    end

endmodule

// File: rtl/tap_timer_mux.sv
// Output tap selector: picks one stage among the upper stages by binary code.
// Assumes the number of upper stages equals 2**SEL_W.
module tap_timer_mux #(
    parameter int TAPS  = 16,
    parameter int SEL_W = 4
) (
    input  logic [TAPS-1:0]  upper,
    input  logic [SEL_W-1:0] sel,
    output logic             tap
);

    // Combinational selection, no pulse shaping
    always_comb begin
        tap = upper[sel];
    end

endmodule

// File: rtl/tap_timer.sv
// Top of the tap-select timer: N_SECT sections of SECT_W stages chained
// by carries. The skip control re-roots the step at section 1. Test mode steps every
// section at once. The output is the upper stage picked by tap_sel.
// Assumes cnt_en is a strobe in the clk domain.
module tap_timer #(
    parameter  int SECT_W = 8,
    parameter  int N_SECT = 3,
    localparam int STAGES = SECT_W * N_SECT,
    localparam int TAPS   = STAGES - SECT_W,
    localparam int SEL_W  = $clog2(TAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             hold,
    input  logic             skip_low,
    input  logic             preset,
    input  logic             clear,
    input  logic [SEL_W-1:0] tap_sel,
    output logic             tap_out
);
    import tap_timer_pkg::*;

    tt_ctl_t            ctl;
    logic [N_SECT-1:0]  inc;
    logic [N_SECT-1:0]  carry;
    logic [STAGES-1:0]  cnt_q;

    tap_timer_ctrl u_ctrl (
        .cnt_en   (cnt_en),
        .hold     (hold),
        .skip_low (skip_low),
        .preset   (preset),
        .clear    (clear),
        .ctl      (ctl)
    );

    for (genvar i = 0; i < N_SECT; i++) begin : g_sect
        if (i == 0) begin : g_root
            // Lowest section: stepped directly unless skipped outside test
            always_comb begin
                inc[i] = ctl.step & (ctl.test | ~ctl.skip);
            end
        end else if (i == 1) begin : g_second
            // Second section: becomes the root when the low section is skipped
            always_comb begin
                inc[i] = (ctl.test | ctl.skip) ? ctl.step : carry[i-1];
            end
        end else begin : g_upper
            // Upper sections: parallel step in test, carry otherwise
            always_comb begin
                inc[i] = ctl.test ? ctl.step : carry[i-1];
            end
        end

        tap_timer_section #(.W(SECT_W)) u_sect (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc     (inc[i]),
            .ld_zero (ctl.zero),
            .ld_ones (ctl.ones),
            .q       (cnt_q[i*SECT_W +: SECT_W]),
            .wrap    (carry[i])
        );
    end

    tap_timer_mux #(.TAPS(TAPS), .SEL_W(SEL_W)) u_mux (
        .upper (cnt_q[STAGES-1:SECT_W]),
        .sel   (tap_sel),
        .tap   (tap_out)
    );

endmodule

// File: rtl/tap_timer_chk.sv
// Checker for tap_timer: relates the control pins to the next state of the
// stage register. Attached by bind below.
module tap_timer_chk #(
    parameter int SECT_W = 8,
    parameter int N_SECT = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cnt_en,
    input logic                     hold,
    input logic                     skip_low,
    input logic                     preset,
    input logic                     clear,
    input logic [SECT_W*N_SECT-1:0] cnt
);
    localparam int STAGES = SECT_W * N_SECT;
    localparam int UP_W   = STAGES - SECT_W;
    localparam logic [STAGES-1:0] ONE24 = {{(STAGES-1){1'b0}}, 1'b1};
    localparam logic [UP_W-1:0]   ONEUP = {{(UP_W-1){1'b0}}, 1'b1};
    localparam logic [SECT_W-1:0] ONE8  = {{(SECT_W-1){1'b0}}, 1'b1};

    logic tm, idle, go;
    always_comb begin
        tm   = skip_low & preset & clear;
        idle = ~preset & ~clear;
        go   = cnt_en & ~hold;
    end

    // R1: reset clears every stage
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> cnt == '0);

    // R3: full-chain step
    a_r3_full_step: assert property (@(posedge clk) disable iff (!rst_n)
        idle && !skip_low && go |=> cnt == $past(cnt) + ONE24);

    // R4: skip mode steps only the upper stages
    a_r4_skip_step: assert property (@(posedge clk) disable iff (!rst_n)
        idle && skip_low && go |=>
        (cnt[SECT_W-1:0] == $past(cnt[SECT_W-1:0])) &&
        (cnt[STAGES-1:SECT_W] == $past(cnt[STAGES-1:SECT_W]) + ONEUP));

    // R5: hold freezes the chain when no load applies
    a_r5_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (idle || tm) && hold |=> $stable(cnt));

    // R6: clear wins outside test mode
    a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear && !tm |=> cnt == '0);

    // R7: preset loads all ones
    a_r7_preset_ones: assert property (@(posedge clk) disable iff (!rst_n)
        preset && !clear |=> cnt == '1);

    // R9: no strobe, no change
    a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        idle && !cnt_en |=> $stable(cnt));

    // R8: in test mode each section steps on its own
    for (genvar s = 0; s < N_SECT; s++) begin : g_tm
        a_r8_section_step: assert property (@(posedge clk) disable iff (!rst_n)
            tm && go |=> cnt[s*SECT_W +: SECT_W] == $past(cnt[s*SECT_W +: SECT_W]) + ONE8);
    end

endmodule

bind tap_timer tap_timer_chk #(.SECT_W(SECT_W), .N_SECT(N_SECT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en   (cnt_en),
    .hold     (hold),
    .skip_low (skip_low),
    .preset   (preset),
    .clear    (clear),
    .cnt      (cnt_q)
);

// File: tb/sim_tap_timer.sv
`timescale 1ns/1ps
// Bench for tap_timer: arithmetic reference model of the 24-bit count, read
// back by sweeping all select codes.
module sim_tap_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0, hold = 1'b0, skip_low = 1'b0;
    logic       preset = 1'b0, clear = 1'b0;
    logic [3:0] tap_sel = 4'd0;
    logic       tap_out;

    int checks = 0;
    int errors = 0;
    logic [23:0] ref_cnt = 24'd0;

    tap_timer u0 (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .hold(hold),
        .skip_low(skip_low), .preset(preset), .clear(clear),
        .tap_sel(tap_sel), .tap_out(tap_out)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Rebuild stages 9..24 by sweeping every select code (R2)
    task automatic read_up(output logic [15:0] v);
        for (int k = 0; k < 16; k++) begin
            tap_sel = 4'(k);
            #0.2;
            v[k] = tap_out;
        end
    endtask

    task automatic expect_up(input string tag);
        logic [15:0] v;
        read_up(v);
        chk(v == ref_cnt[23:8], tag, {8'h0, v}, {8'h0, ref_cnt[23:8]});
    endtask

    // n strobes in the current mode, model updated arithmetically
    task automatic run(input int n);
        @(negedge clk);
        cnt_en = 1'b1;
        repeat (n) @(negedge clk);
        cnt_en = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (hold) begin
                ref_cnt = ref_cnt;
            end else if (skip_low && preset && clear) begin
                ref_cnt[7:0]   = ref_cnt[7:0] + 8'd1;
                ref_cnt[15:8]  = ref_cnt[15:8] + 8'd1;
                ref_cnt[23:16] = ref_cnt[23:16] + 8'd1;
            end else if (skip_low) begin
                ref_cnt[23:8] = ref_cnt[23:8] + 16'd1;
            end else begin
                ref_cnt = ref_cnt + 24'd1;
            end
        end
    endtask

    task automatic pulse_load(input bit p, input bit c);
        @(negedge clk);
        preset = p; clear = c;
        @(negedge clk);
        preset = 1'b0; clear = 1'b0;
    endtask

    initial begin
        #(8 * 190000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        // R1: reset, with strobe and preset active, still yields zero
        cnt_en = 1'b1; preset = 1'b1;
        repeat (3) @(negedge clk);
        cnt_en = 1'b0; preset = 1'b0;
        rst_n = 1'b1;
        ref_cnt = 24'd0;
        expect_up("R1 reset state");

        // R3 boundary: 255 steps leave the upper stages at 0, the 256th carries
        run(255);
        expect_up("R3 before first carry");
        run(1);
        expect_up("R3 first carry into stage 9");
        // R2/R3: sweep of counts, every code read each time
        for (int j = 0; j < 12; j++) begin
            run(257 + 97 * j);
            expect_up("R2 R3 count sweep");
        end

        // R5: hold with the strobe high
        @(negedge clk); hold = 1'b1;
        run(40);
        @(negedge clk); hold = 1'b0;
        expect_up("R5 hold blocks steps");

        // R9: idle cycles
        repeat (30) @(negedge clk);
        expect_up("R9 no strobe no change");

        // R7: preset gives all ones, then R3 wrap to zero
        pulse_load(1'b1, 1'b0);
        ref_cnt = 24'hFFFFFF;
        expect_up("R7 preset all ones");
        run(1);
        expect_up("R3 wrap from all ones");

        // R6: clear with preset also high wins
        run(700);
        pulse_load(1'b1, 1'b1);
        ref_cnt = 24'd0;
        expect_up("R6 clear over preset");

        // R7 over counting: preset while strobing
        @(negedge clk); preset = 1'b1; cnt_en = 1'b1;
        @(negedge clk); preset = 1'b0; cnt_en = 1'b0;
        ref_cnt = 24'hFFFFFF;
        expect_up("R7 preset overrides step");

        // R4: skip mode keeps low byte full; one skip step wraps upper to 0
        @(negedge clk); skip_low = 1'b1;
        run(1);
        expect_up("R4 skip wrap upper");
        @(negedge clk); skip_low = 1'b0;
        run(1);   // low byte 0xFF + 1 carries into stage 9
        expect_up("R4 low stages held in skip");

        // R4: full 16-bit skip cycle
        pulse_load(1'b0, 1'b1);
        ref_cnt = 24'd0;
        @(negedge clk); skip_low = 1'b1;
        for (int j = 0; j < 16; j++) begin
            run(4096);
            expect_up("R4 skip sweep");
        end
        @(negedge clk); skip_low = 1'b0;
        v = 16'h0;
        chk(ref_cnt[23:8] == 16'h0, "R4 skip cycle length", {8'h0, ref_cnt[23:8]}, 24'h0);

        // R8: test mode, sections count in parallel without carry
        @(negedge clk); skip_low = 1'b1; preset = 1'b1; clear = 1'b1;
        run(5);
        expect_up("R8 test mode parallel step");
        run(260);
        expect_up("R8 test mode no carry");
        @(negedge clk); hold = 1'b1;
        run(9);
        @(negedge clk); hold = 1'b0;
        expect_up("R5 hold in test mode");
        repeat (5) @(negedge clk);
        expect_up("R8 preset and clear ignored in test");
        @(negedge clk); skip_low = 1'b0; preset = 1'b0; clear = 1'b0;
        // low section counted too: it carries after 256 - low steps
        run(255 - int'(ref_cnt[7:0]));
        expect_up("R8 low section before carry");
        run(1);
        expect_up("R8 low section counted in test");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule